// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and lower memory. It takes single-word stores and groups them by aligned block. Each block holds four 32-bit words. An entry keeps one block address, four word slots and a valid bit for each slot. A store to a block that already waits in an entry is folded into that entry. A store to any other block opens a fresh entry. As a result, a run of word stores to one block leaves as one memory transaction that carries a word mask.

Entries leave in the order they were opened. The oldest entry is copied into a registered drain stage and is offered with a valid/ready handshake. The copied block is then no longer open for merging. A lookup port compares a block address against everything that is still pending, which covers both the entries and the drain stage. A read miss can use this port to decide whether it may bypass the pending writes.

Top module: `merge_wbuf`

## Requirements
- R1: During and right after reset, `mem_valid` is 0, `st_ready` is 1 and `lk_hit` is 0.
- R2: A store whose block matches no open entry takes a new entry. When that entry drains, its mask has only the stored word's bit set, and every other data word is zero.
- R3: A store to a block that already has an open entry merges into it. Stores to byte addresses 0x100, 0x104, 0x108 and 0x10C while the drain is stalled drain as one transaction with block 0x10 and mask 4'b1111. At most one open entry exists per block.
- R4: A store to a word that is already valid in its entry replaces that word's data. The mask bit stays set.
- R5: Transactions leave in the order their entries were opened, one entry per handshake.
- R6: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_blk`, `mem_data` and `mem_mask` hold their values.
- R7: `st_ready` is 0 only when all four entries are in use and none of them holds the store's block. A full buffer still accepts a store that merges.
- R8: In the same cycle, `lk_hit` is 1 when an open entry or the presented drain transaction has the block of `lk_addr`, whatever its mask, and 0 otherwise.
- R9: A store to the block currently presented on the drain port is not merged into it. It opens a new entry that drains later.
- R10: The word slot is `addr[3:2]` and the block is `addr[31:4]`. `addr[1:0]` is ignored. Word w of `mem_data` is bits [32w+31:32w], and mask bit w belongs to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store word |
| lk_addr | input | 32 | Lookup byte address |
| lk_hit | output | 1 | A pending write covers the lookup block |
| mem_valid | output | 1 | Drain transaction presented |
| mem_ready | input | 1 | Lower memory takes the transaction |
| mem_blk | output | 28 | Block address of the transaction |
| mem_data | output | 128 | Four words, word 0 in the low bits |
| mem_mask | output | 4 | Valid bit per word |

## Verification
The assertions assume that reset is applied before the first store and that `mem_ready` is a plain level that may change in any cycle. They also assume the store side keeps `st_valid`, `st_addr` and `st_data` steady until a store is accepted, so a stall never drops a write. The stimulus drives every input just after the falling edge and holds each store until `st_ready` is seen. Random addresses stay within eight blocks, so merges, full-buffer stalls and stores to the block being drained happen often. `mem_ready` is toggled at random so the drain stage is both held and released.

// File: rtl/merge_wbuf_pkg.sv
package merge_wbuf_pkg;

  // index of the lowest set bit, 0 when none is set
  function automatic int first_set(input logic [63:0] v);
    int r;
    r = 0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/merge_wbuf_cmp.sv
module merge_wbuf_cmp #(
  parameter int DEPTH = 4,
  parameter int BW    = 28
) (
  input  logic [DEPTH-1:0] vld,
  input  logic [DEPTH-1:0] excl,
  input  logic [BW-1:0]    blk [DEPTH],
  input  logic [BW-1:0]    key,
  output logic [DEPTH-1:0] hit
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = vld[i] && !excl[i] && (blk[i] == key);
  end
endmodule

// File: rtl/merge_wbuf_ring.sv
module merge_wbuf_ring #(
  parameter int DEPTH = 4,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic            pop,
  output logic [IDXW-1:0] head,
  output logic [IDXW-1:0] tail,
  output logic [IDXW:0]   occ,
  output logic            full,
  output logic            empty
);
  function automatic logic [IDXW-1:0] step(input logic [IDXW-1:0] p);
    return (p == IDXW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else begin
      if (push) tail <= step(tail);
      if (pop)  head <= step(head);
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign full  = (occ == (IDXW + 1)'(DEPTH));
  assign empty = (occ == '0);
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int WORDS = 4,
  parameter int DEPTH = 4,
  localparam int BYTEW = DW / 8,
  localparam int OFFW  = $clog2(WORDS * BYTEW),
  localparam int BW    = AW - OFFW,
  localparam int LW    = WORDS * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             st_valid,
  output logic             st_ready,
  input  logic [AW-1:0]    st_addr,
  input  logic [DW-1:0]    st_data,
  input  logic [AW-1:0]    lk_addr,
  output logic             lk_hit,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [BW-1:0]    mem_blk,
  output logic [LW-1:0]    mem_data,
  output logic [WORDS-1:0] mem_mask
);
  import merge_wbuf_pkg::*;

  localparam int IDXW  = $clog2(DEPTH);
  localparam int WSELW = $clog2(WORDS);
  localparam int BSELW = $clog2(BYTEW);

  // entry storage
  logic [DEPTH-1:0] e_vld;
  logic [BW-1:0]    e_blk  [DEPTH];
  logic [WORDS-1:0] e_mask [DEPTH];
  logic [LW-1:0]    e_data [DEPTH];

  logic [IDXW-1:0]  head, tail;
  logic [IDXW:0]    occ;
  logic             full, empty;

  logic [BW-1:0]    st_blk, lk_blk;
  logic [WSELW-1:0] st_w;
  logic [DEPTH-1:0] excl, st_hitv, lk_hitv;
  logic             st_hit, acc, alloc, launch;
  logic [IDXW-1:0]  st_idx;
  logic [LW-1:0]    ins_data;
  logic [WORDS-1:0] ins_mask;
  logic             unused_low;

  assign st_blk     = st_addr[AW-1:OFFW];
  assign st_w       = st_addr[BSELW +: WSELW];
  assign lk_blk     = lk_addr[AW-1:OFFW];
  assign unused_low = ^{st_addr[BSELW-1:0], lk_addr[OFFW-1:0]};

  // the head leaves for the drain stage when that stage is free or being emptied
  assign launch = !empty && (!mem_valid || mem_ready);

  always_comb begin
    excl = '0;
    if (launch) excl[head] = 1'b1;
  end

  merge_wbuf_cmp #(.DEPTH(DEPTH), .BW(BW)) u_st_cmp (
    .vld(e_vld), .excl(excl), .blk(e_blk), .key(st_blk), .hit(st_hitv)
  );

  merge_wbuf_cmp #(.DEPTH(DEPTH), .BW(BW)) u_lk_cmp (
    .vld(e_vld), .excl('0), .blk(e_blk), .key(lk_blk), .hit(lk_hitv)
  );

  assign st_hit   = |st_hitv;
  assign st_idx   = IDXW'(first_set(64'(st_hitv)));
  assign st_ready = st_hit || !full;
  assign acc      = st_valid && st_ready;
  assign alloc    = acc && !st_hit;

  assign lk_hit = (|lk_hitv) || (mem_valid && (mem_blk == lk_blk));

  always_comb begin
    ins_data = '0;
    ins_data[int'(st_w) * DW +: DW] = st_data;
    ins_mask = '0;
    ins_mask[st_w] = 1'b1;
  end

  merge_wbuf_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst(rst), .push(alloc), .pop(launch),
    .head(head), .tail(tail), .occ(occ), .full(full), .empty(empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      e_vld     <= '0;
      mem_valid <= 1'b0;
      mem_blk   <= '0;
      mem_data  <= '0;
      mem_mask  <= '0;
    end else begin
      if (launch) begin
        mem_valid   <= 1'b1;
        mem_blk     <= e_blk[head];
        mem_data    <= e_data[head];
        mem_mask    <= e_mask[head];
        e_vld[head] <= 1'b0;
      end else if (mem_ready) begin
        mem_valid <= 1'b0;
      end
      if (acc && st_hit) begin
        e_data[st_idx][int'(st_w) * DW +: DW] <= st_data;
        e_mask[st_idx][st_w] <= 1'b1;
      end
      if (alloc) begin
        e_vld[tail]  <= 1'b1;
        e_blk[tail]  <= st_blk;
        e_mask[tail] <= ins_mask;
        e_data[tail] <= ins_data;
      end
    end
  end
endmodule

// File: rtl/merge_wbuf_chk.sv
module merge_wbuf_chk #(
  parameter int DEPTH = 4,
  parameter int BW    = 28,
  parameter int LW    = 128,
  parameter int WORDS = 4,
  localparam int IDXW = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             st_ready,
  input logic             lk_hit,
  input logic             mem_valid,
  input logic             mem_ready,
  input logic [BW-1:0]    mem_blk,
  input logic [LW-1:0]    mem_data,
  input logic [WORDS-1:0] mem_mask,
  input logic [IDXW:0]    occ,
  input logic [DEPTH-1:0] hitv
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!mem_valid && st_ready && !lk_hit));

  assert_one_mask_R2: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_mask != '0));

  assert_unique_block_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hitv));

  assert_occ_bound_R5: assert property (@(posedge clk) disable iff (rst)
    occ <= (IDXW + 1)'(DEPTH));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_blk)
                                   && $stable(mem_data) && $stable(mem_mask)));

  assert_stall_full_R7: assert property (@(posedge clk) disable iff (rst)
    !st_ready |-> (occ == (IDXW + 1)'(DEPTH)));

  assert_idle_miss_R8: assert property (@(posedge clk) disable iff (rst)
    ((occ == '0) && !mem_valid) |-> !lk_hit);
endmodule

bind merge_wbuf merge_wbuf_chk #(
  .DEPTH(DEPTH), .BW(BW), .LW(LW), .WORDS(WORDS)
) u_chk (
  .clk(clk), .rst(rst), .st_ready(st_ready), .lk_hit(lk_hit),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_blk(mem_blk),
  .mem_data(mem_data), .mem_mask(mem_mask), .occ(occ), .hitv(st_hitv)
);

// File: tb/tb_merge_wbuf.sv
`timescale 1ns/1ps
module tb_merge_wbuf;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         st_valid = 1'b0;
  logic         st_ready;
  logic [31:0]  st_addr = '0;
  logic [31:0]  st_data = '0;
  logic [31:0]  lk_addr = '0;
  logic         lk_hit;
  logic         mem_valid;
  logic         mem_ready = 1'b0;
  logic [27:0]  mem_blk;
  logic [127:0] mem_data;
  logic [3:0]   mem_mask;

  int errors = 0;
  int checks = 0;
  int n_stores = 0;
  bit done = 1'b0;

  logic [27:0]  q_blk  [$];
  logic [3:0]   q_mask [$];
  logic [127:0] q_data [$];
  logic [31:0]  memimg [int];
  logic [31:0]  refmem [int];

  merge_wbuf dut (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .lk_addr(lk_addr), .lk_hit(lk_hit),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_blk(mem_blk),
    .mem_data(mem_data), .mem_mask(mem_mask)
  );

  always #2.5 clk = ~clk;

  // monitor: record every completed drain handshake
  always @(posedge clk) begin
    if (!rst && mem_valid && mem_ready) begin
      q_blk.push_back(mem_blk);
      q_mask.push_back(mem_mask);
      q_data.push_back(mem_data);
      for (int w = 0; w < 4; w++)
        if (mem_mask[w]) memimg[int'(mem_blk) * 4 + w] = mem_data[w*32 +: 32];
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] words(input logic [31:0] w3, input logic [31:0] w2,
                                          input logic [31:0] w1, input logic [31:0] w0);
    return {w3, w2, w1, w0};
  endfunction

  task automatic do_store(input logic [31:0] a, input logic [31:0] d);
    bit ok;
    ok = 1'b0;
    @(negedge clk);
    st_valid = 1'b1;
    st_addr  = a;
    st_data  = d;
    while (!ok) begin
      #1;
      ok = st_ready;
      @(posedge clk);
      if (!ok) @(negedge clk);
    end
    refmem[int'(a >> 2)] = d;
    n_stores++;
    #1 st_valid = 1'b0;
  endtask

  task automatic look(input logic [31:0] a, input bit exp, input string tag);
    lk_addr = a;
    #1;
    check(lk_hit == exp, tag, 128'(lk_hit), 128'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    check(mem_valid == 1'b0, "R1 mem_valid in reset", 128'(mem_valid), 128'(0));
    check(st_ready == 1'b1, "R1 st_ready in reset", 128'(st_ready), 128'(1));
    check(lk_hit == 1'b0, "R1 lk_hit in reset", 128'(lk_hit), 128'(0));
    @(negedge clk);
    rst = 1'b0;

    // R2 R10: lone store, drain stalled by mem_ready low
    do_store(32'h0000_0200, 32'hA000_0001);
    @(negedge clk);
    @(negedge clk);
    #1;
    check(mem_valid == 1'b1, "R2 mem_valid after launch", 128'(mem_valid), 128'(1));
    check(mem_blk == 28'h20, "R10 mem_blk", 128'(mem_blk), 128'(28'h20));
    check(mem_mask == 4'b0001, "R2 mask single word", 128'(mem_mask), 128'(4'b0001));
    check(mem_data == words(0, 0, 0, 32'hA000_0001), "R2 zero other words",
          mem_data, words(0, 0, 0, 32'hA000_0001));

    // R3 R4 R8 merges behind the held drain stage
    do_store(32'h0000_0100, 32'h11);
    look(32'h0000_010C, 1'b1, "R8 hit on unwritten word of open entry");
    look(32'h0000_020C, 1'b1, "R8 hit on presented transaction");
    look(32'h0000_0300, 1'b0, "R8 miss on other block");
    do_store(32'h0000_0104, 32'h22);
    do_store(32'h0000_0108, 32'h33);
    do_store(32'h0000_010C, 32'h44);
    do_store(32'h0000_0104, 32'h55);
    do_store(32'h0000_0208, 32'h66); // R9 block of the presented transaction
    do_store(32'h0000_0400, 32'h77);
    do_store(32'h0000_0500, 32'h88);

    // R7 full buffer: a new block stalls, a merging store goes through
    @(negedge clk);
    st_valid = 1'b1;
    st_addr  = 32'h0000_0600;
    st_data  = 32'hDEAD;
    #1;
    check(st_ready == 1'b0, "R7 stall on full with new block", 128'(st_ready), 128'(0));
    st_addr = 32'h0000_0506;
    st_data = 32'h99;
    #1;
    check(st_ready == 1'b1, "R7 merge accepted while full", 128'(st_ready), 128'(1));
    st_valid = 1'b0;
    do_store(32'h0000_0506, 32'h99); // R10 low address bits ignored

    @(negedge clk);
    #1;
    check(mem_valid && mem_blk == 28'h20 && mem_mask == 4'b0001
          && mem_data == words(0, 0, 0, 32'hA000_0001), "R6 held while stalled",
          {mem_blk, mem_mask}, {28'h20, 4'b0001});
    check(q_blk.size() == 0, "R6 no handshake while stalled", 128'(q_blk.size()), 128'(0));

    @(negedge clk);
    mem_ready = 1'b1;
    repeat (12) @(negedge clk);
    check(q_blk.size() == 5, "R5 transaction count", 128'(q_blk.size()), 128'(5));
    if (q_blk.size() == 5) begin
      check(q_blk[0] == 28'h20 && q_mask[0] == 4'b0001, "R5 first is oldest",
            {q_blk[0], q_mask[0]}, {28'h20, 4'b0001});
      check(q_blk[1] == 28'h10 && q_mask[1] == 4'b1111, "R3 four words in one entry",
            {q_blk[1], q_mask[1]}, {28'h10, 4'b1111});
      check(q_data[1] == words(32'h44, 32'h33, 32'h55, 32'h11), "R4 overwrite in place",
            q_data[1], words(32'h44, 32'h33, 32'h55, 32'h11));
      check(q_blk[2] == 28'h20 && q_mask[2] == 4'b0100, "R9 no merge into draining block",
            {q_blk[2], q_mask[2]}, {28'h20, 4'b0100});
      check(q_data[2] == words(0, 32'h66, 0, 0), "R9 new entry data",
            q_data[2], words(0, 32'h66, 0, 0));
      check(q_blk[3] == 28'h40 && q_mask[3] == 4'b0001, "R5 fourth in order",
            {q_blk[3], q_mask[3]}, {28'h40, 4'b0001});
      check(q_blk[4] == 28'h50 && q_mask[4] == 4'b0011
            && q_data[4] == words(0, 0, 32'h99, 32'h88), "R7 merged while full",
            {q_blk[4], q_mask[4]}, {28'h50, 4'b0011});
    end
    check(mem_valid == 1'b0, "R5 drained", 128'(mem_valid), 128'(0));
    look(32'h0000_0500, 1'b0, "R8 miss after drain");

    // random phase: random stores, random drain back-pressure
    begin
      int tx0;
      int st0;
      tx0 = q_blk.size();
      st0 = n_stores;
      fork
        begin
          for (int n = 0; n < 2500; n++) begin
            logic [31:0] a;
            a = 32'h0000_1000 + (($urandom % 8) << 4) + (($urandom % 4) << 2) + ($urandom % 4);
            do_store(a, $urandom);
            if ($urandom % 5 == 0) @(negedge clk);
          end
          done = 1'b1;
        end
        begin
          while (!done) begin
            @(negedge clk);
            mem_ready = ($urandom % 3) != 0;
          end
        end
      join
      @(negedge clk);
      mem_ready = 1'b1;
      repeat (20) @(negedge clk);
      check(mem_valid == 1'b0, "R5 random drain complete", 128'(mem_valid), 128'(0));
      check(q_blk.size() - tx0 < n_stores - st0, "R3 random stores merged",
            128'(q_blk.size() - tx0), 128'(n_stores - st0));
    end

    foreach (refmem[k]) begin
      check(memimg.exists(k) && memimg[k] == refmem[k], "R5 final memory word",
            memimg.exists(k) ? 128'(memimg[k]) : 128'hX, 128'(refmem[k]));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule